// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

This block takes a vector of already synchronised GPIO pins and maps any of them onto a smaller set of interrupt lines. Each line has its own source selector and trigger setting, written through a simple 32-bit register port. The default build has 39 pins and 20 lines. A trigger is one of level high, level low, rising edge, falling edge or both edges. A single global enable gates every output.

Software writes the selectors, the per-line polarity, the single-edge bits and the both-edge bits, then sets the global enable. Level lines are registered copies of the chosen pin, inverted when the polarity bit asks for it. Edge lines produce a one-clock pulse in the cycle after the transition is seen. The edge history keeps sampling while the block is disabled. This means turning the enable on never creates a false edge.

Top module: `gpio_irq_router`

## Requirements
- R1: After a synchronous reset every register reads back as zero and every interrupt output is low.
- R2: While the global enable (word 0x00, bit 31) is clear, all outputs are low one clock later. The edge history keeps following the pins, so setting the enable while a pin holds steady produces no edge pulse.
- R3: Word 4X (X = 1..10) holds two 6-bit selectors. Bits 5:0 choose the source for line 2X-2 and bits 21:16 choose it for line 2X-1. A selector value v below 39 routes pin v.
- R4: A selector value from 39 to 63 routes a constant 0. A level-high line with such a selector stays low, and a level-low line with it stays high.
- R5: A line is in level mode when its single-edge bit (word 0x30, bit n) is clear and its both-edge bit is clear. In level mode the output equals the selected pin one clock later, inverted when the polarity bit (word 0x00, bit n) is 1.
- R6: When the single-edge bit is 1 and the both-edge bit is 0, the line uses polarity 0 for rising edges and polarity 1 for falling edges. The output is high for exactly one clock, in the cycle after the clock edge that first samples the new pin value.
- R7: When a line's both-edge bit (word 0x2C, bit n) is 1, the line pulses for one clock on either transition, whatever its polarity and single-edge bits hold.
- R8: Reads return data one clock after the address is presented. Word 0x00 reads back as enable in bit 31 and polarity in bits 19:0. Words 0x2C and 0x30 read back their bits 19:0. Selector words read back their two 6-bit fields. All other bits, and all addresses above 0x30, read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Byte address of the register word |
| reg_we | input | 1 | Write strobe for the addressed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| gpio_i | input | 39 | Synchronised GPIO pin vector |
| irq_o | output | 20 | Interrupt output lines |

## Verification
On every cycle, the assertions check the following:
- a disabled block drives all outputs low;
- a level line tracks its routed pin after one register;
- a single-edge pulse never lasts two cycles while the trigger setting is held;
- an out-of-range selector with non-inverting, non-both-edge settings keeps its line low;
- reads of unmapped words return zero.

Only the bench scenarios can show three things. The first is the real placement of selector fields in the register words. The second is that the both-edge bit overrides a conflicting polarity and single-edge setting. The third is that enabling the block while a pin holds high yields no pulse.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_W  = 32;
  localparam int EN_BIT = 31;
  localparam int HI_OFS = 16;

  // Trigger evaluation shared by every line: cur is the routed value now,
  // last is the routed value one clock earlier.
  function automatic logic trig_fire(input logic cur, input logic last,
                                     input logic inv, input logic edge_en,
                                     input logic any_edge);
    logic hit;
    if (any_edge)
      hit = cur ^ last;
    else if (edge_en)
      hit = inv ? (last & ~cur) : (cur & ~last);
    else
      hit = cur ^ inv;
    return hit;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES = 20,
  parameter int SEL_W   = 6,
  parameter int ADDR_W  = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ADDR_W-1:0]               addr,
  input  logic                            we,
  input  logic [REG_W-1:0]                wdata,
  output logic [REG_W-1:0]                rdata,
  output logic                            enable_o,
  output logic [N_LINES-1:0]              pol_o,
  output logic [N_LINES-1:0]              edge_o,
  output logic [N_LINES-1:0]              both_o,
  output logic [N_LINES-1:0][SEL_W-1:0]   sel_o
);
  localparam int IDX_W   = ADDR_W - 2;
  localparam int N_SELWD = (N_LINES + 1) / 2;
  localparam int W_BOTH  = N_SELWD + 1;
  localparam int W_EDGE  = N_SELWD + 2;

  logic [IDX_W-1:0] idx;
  logic [1:0]       unused_lsb;
  logic             unused_wdata;
  assign idx          = addr[ADDR_W-1:2];
  assign unused_lsb   = addr[1:0];
  assign unused_wdata = ^wdata;

  logic                          en_q;
  logic [N_LINES-1:0]            pol_q, edge_q, both_q;
  logic [N_LINES-1:0][SEL_W-1:0] sel_q;
  logic [REG_W-1:0]              rd_word, rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      pol_q  <= '0;
      edge_q <= '0;
      both_q <= '0;
      sel_q  <= '0;
    end else if (we) begin
      if (idx == '0) begin
        en_q  <= wdata[EN_BIT];
        pol_q <= wdata[N_LINES-1:0];
      end
      if (idx == IDX_W'(W_BOTH)) both_q <= wdata[N_LINES-1:0];
      if (idx == IDX_W'(W_EDGE)) edge_q <= wdata[N_LINES-1:0];
      for (int i = 0; i < N_LINES; i++) begin
        if (idx == IDX_W'(i / 2 + 1))
          sel_q[i] <= wdata[(i % 2) * HI_OFS +: SEL_W];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (idx == '0) begin
      rd_word[EN_BIT]      = en_q;
      rd_word[N_LINES-1:0] = pol_q;
    end
    if (idx == IDX_W'(W_BOTH)) rd_word[N_LINES-1:0] = both_q;
    if (idx == IDX_W'(W_EDGE)) rd_word[N_LINES-1:0] = edge_q;
    for (int i = 0; i < N_LINES; i++) begin
      if (idx == IDX_W'(i / 2 + 1))
        rd_word[(i % 2) * HI_OFS +: SEL_W] = sel_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_word;
  end

  assign rdata    = rdata_q;
  assign enable_o = en_q;
  assign pol_o    = pol_q;
  assign edge_o   = edge_q;
  assign both_o   = both_q;
  assign sel_o    = sel_q;

  // R8: words past the last control word read back as zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (idx > IDX_W'(W_EDGE)) |=> (rdata == '0));

  // R1: the cycle after reset the control state is cleared
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!enable_o && pol_o == '0 && edge_o == '0 && both_o == '0));
endmodule

// File: rtl/irq_line.sv
module irq_line
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 39,
  parameter int SEL_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] gpio_i,
  input  logic [SEL_W-1:0]  sel,
  input  logic              pol,
  input  logic              edge_en,
  input  logic              both,
  input  logic              enable,
  output logic              irq_o
);
  logic src, prev_q, irq_q, in_range;

  assign in_range = (int'(sel) < N_PINS);

  always_comb begin
    src = 1'b0;
    if (in_range) src = gpio_i[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= src;
      irq_q  <= enable & trig_fire(src, prev_q, pol, edge_en, both);
    end
  end

  assign irq_o = irq_q;

  // R2: disabled block gives a low line on the next cycle
  a_r2_off_low: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !irq_o);

  // R5: level line equals the routed pin xor polarity one clock later
  a_r5_level_track: assert property (@(posedge clk) disable iff (rst)
    (enable && !edge_en && !both && in_range) |=> (irq_o == $past(gpio_i[sel] ^ pol)));

  // R6: single-edge pulse lasts one cycle while the setting is held
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (edge_en && !both && $past(edge_en) && !$past(both) && (pol == $past(pol)) && irq_o)
      |=> !irq_o);

  // R4: out-of-range selector acts as a constant 0 source
  a_r4_null_source: assert property (@(posedge clk) disable iff (rst)
    (!in_range && !pol && !both) |=> !irq_o);
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS  = 39,
  parameter int N_LINES = 20,
  parameter int SEL_W   = 6,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [N_PINS-1:0]  gpio_i,
  output logic [N_LINES-1:0] irq_o
);
  logic                          cfg_en;
  logic [N_LINES-1:0]            cfg_pol, cfg_edge, cfg_both;
  logic [N_LINES-1:0][SEL_W-1:0] cfg_sel;

  irq_cfg_regs #(
    .N_LINES (N_LINES),
    .SEL_W   (SEL_W),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (reg_addr),
    .we       (reg_we),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .enable_o (cfg_en),
    .pol_o    (cfg_pol),
    .edge_o   (cfg_edge),
    .both_o   (cfg_both),
    .sel_o    (cfg_sel)
  );

  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    irq_line #(
      .N_PINS (N_PINS),
      .SEL_W  (SEL_W)
    ) u_line (
      .clk     (clk),
      .rst     (rst),
      .gpio_i  (gpio_i),
      .sel     (cfg_sel[n]),
      .pol     (cfg_pol[n]),
      .edge_en (cfg_edge[n]),
      .both    (cfg_both[n]),
      .enable  (cfg_en),
      .irq_o   (irq_o[n])
    );
  end

  // R1: outputs low on the cycle after reset
  a_r1_out_reset: assert property (@(posedge clk) rst |=> (irq_o == '0));
endmodule

// File: tb/tb_gpio_irq_router.sv
`timescale 1ns/1ps
module tb_gpio_irq_router;
  localparam int NP = 39;
  localparam int NL = 20;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] gpio = '0;
  logic [NL-1:0] irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_irq_router dut (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (addr),
    .reg_we    (we),
    .reg_wdata (wdata),
    .reg_rdata (rdata),
    .gpio_i    (gpio),
    .irq_o     (irq)
  );

  // {pin5 value, expected irq[4:0]}: line0 rise, 1 fall, 2 both, 3 level high, 4 level low
  localparam logic [5:0] VEC [8] = '{
    6'b0_10000, 6'b1_01101, 6'b1_01000, 6'b0_10110,
    6'b0_10000, 6'b1_01101, 6'b0_10110, 6'b1_01101
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  initial begin
    #(5.0 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", 32'(irq), 32'h0);
    rd(6'h00, r); check("R1 word0 reset", r, 32'h0);
    rd(6'h04, r); check("R1 sel word reset", r, 32'h0);
    rd(6'h30, r); check("R1 edge word reset", r, 32'h0);

    // R8 readback masks
    wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, r); check("R8 word0 mask", r, 32'h800F_FFFF);
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, r); check("R8 sel word mask", r, 32'h003F_003F);
    wr(6'h2C, 32'hFFFF_FFFF); rd(6'h2C, r); check("R8 both word mask", r, 32'h000F_FFFF);
    rd(6'h34, r); check("R8 unmapped 0x34", r, 32'h0);
    rd(6'h3C, r); check("R8 unmapped 0x3C", r, 32'h0);
    wr(6'h00, 32'h0); wr(6'h04, 32'h0); wr(6'h2C, 32'h0);

    // trigger set-up on pin 5; line 2 has conflicting pol/edge bits (R7)
    wr(6'h04, 32'h0005_0005);
    wr(6'h08, 32'h0005_0005);
    wr(6'h0C, 32'h0000_0005);
    wr(6'h30, 32'h0000_0007);
    wr(6'h2C, 32'h0000_0004);
    wr(6'h00, 32'h8000_0016);
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      gpio[5] = VEC[i][5];
      @(negedge clk);
      check($sformatf("R5 R6 R7 vector %0d", i), 32'(irq), {27'h0, VEC[i][4:0]});
      @(negedge clk);
    end

    // R2: disable, raise pin, then enable with pin held
    gpio[5] = 1'b0;
    repeat (2) @(negedge clk);
    wr(6'h00, 32'h0000_0016);
    gpio[5] = 1'b1;
    @(negedge clk);
    check("R2 outputs low while disabled", 32'(irq), 32'h0);
    @(negedge clk);
    wr(6'h00, 32'h8000_0016);
    @(negedge clk);
    check("R2 no spurious edge on enable", 32'(irq), 32'h0000_0008);

    // R3: line 7 in upper half of word 0x10 takes pin 38, line 6 lower takes pin 0
    wr(6'h10, 32'h0026_0000);
    gpio[38] = 1'b1;
    @(negedge clk);
    check("R3 upper selector line7", 32'(irq[7:6]), 32'h2);
    gpio[0] = 1'b1;
    @(negedge clk);
    check("R3 lower selector line6", 32'(irq[7:6]), 32'h3);
    gpio[0] = 1'b0;

    // R4: out-of-range selector on line 8
    wr(6'h14, 32'h0000_002D);
    gpio = '1;
    @(negedge clk);
    @(negedge clk);
    check("R4 null source level high", 32'(irq[8]), 32'h0);
    wr(6'h00, 32'h8000_0116);
    @(negedge clk);
    check("R4 null source level low", 32'(irq[8]), 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule